// File: doc/BRIEF.md
# Delayed Trigger Gate Generator

This block turns an asynchronous timing-receiver strobe into a clean, clock-aligned gate level. The strobe is first brought into the clock domain by a short synchronizer chain, and its rising and falling edges are found by comparing consecutive synchronized samples. A rising edge arms the block. After an optional programmable start delay, the gate opens.

How the gate closes depends on a mode bit. In follow mode (mode bit 0) the gate stays open as long as the synchronized strobe is high. After the strobe falls, an optional programmable stop delay runs, and then the gate drops. In this mode the length word has no effect. In timed mode (mode bit 1) the gate stays open for exactly the programmed number of clock cycles, whatever the strobe does. In this mode the stop delay has no effect.

While a start delay, an open gate or a stop delay is in progress, further strobe edges are ignored. The length word and both delay words are unsigned 32-bit cycle counts, and they are expected to be held steady while the block is busy.

Top module: `trig_gate`

## Requirements
- R1: The strobe can first be sampled high at clock edge n. With a zero start delay, gateOut is high from edge n+2 onward, which is a two-flop synchronizer plus one control cycle.
- R2: In follow mode (fixedMode=0) with a zero stop delay, gateOut goes low at edge m+2, where m is the first edge at which the strobe is sampled low. gateLen has no effect in this mode.
- R3: A start delay of D cycles postpones the gate rise by exactly D cycles, to edge n+2+D, in both modes.
- R4: In follow mode, a stop delay of S cycles postpones the gate fall by exactly S cycles, to edge m+2+S.
- R5: In timed mode (fixedMode=1) with length L>0, gateOut stays high for exactly L cycles. This holds whether the strobe falls before the gate ends or stays high past it. stopDly has no effect in this mode.
- R6: In timed mode, a length of zero produces no gate at all, with or without a start delay.
- R7: A rising edge of the strobe that arrives during a start delay, an open gate or a stop delay has no effect. A new gate needs a fresh rising edge after the gate has closed, so a strobe still held high after a timed gate ends does not reopen it.
- R8: While rstN is low, and after it is released until a rising strobe edge is seen, gateOut is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigIn | input | 1 | Raw asynchronous timing strobe |
| fixedMode | input | 1 | 0: gate follows strobe; 1: gate lasts gateLen cycles |
| gateLen | input | 32 | Gate length in cycles for timed mode |
| startDly | input | 32 | Cycles between detected rise and gate opening |
| stopDly | input | 32 | Extra cycles before gate closing in follow mode |
| gateOut | output | 1 | Gate level |

## Verification
The hardest situation to reach is a second strobe edge that arrives while the block is busy. To land it, that edge must fall inside the start-delay window or the open-gate window, and those windows are set by cycle counts that the stimulus has to match. The bench drives its strobe pulses at counted clock positions: two short pulses spaced well inside a 10-cycle start delay, and then further pulses inside a 20-cycle timed gate. It then checks that exactly one gate appears, and that this gate's rise and fall cycles are the ones the first edge alone predicts. A strobe held high well past the end of a timed gate covers the case where no fresh rising edge arrives after the gate closes.

// File: rtl/trig_gate_pkg.sv
package trig_gate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_OPEN  = 2'd2,
    ST_HOLD  = 2'd3
  } gateState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldStart;
    logic ldLen;
    logic ldStop;
    logic dec;
    logic setGate;
    logic clrGate;
  } gateStrb_t;

endpackage

// File: rtl/trig_gate_dpath.sv
module trig_gate_dpath
  import trig_gate_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic [CNT_W-1:0] gateLen,
  input  logic [CNT_W-1:0] startDly,
  input  logic [CNT_W-1:0] stopDly,
  input  gateStrb_t        strb,
  output logic             trigRise,
  output logic             trigLvl,
  output logic             cntOne,
  output logic             gateOut
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [SYNC_MSB:0] syncChain;
  logic              lvlPrev;
  logic [CNT_W-1:0]  cnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= trigIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_MSB-1:0], trigIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lvlPrev <= 1'b0;
    else       lvlPrev <= syncChain[SYNC_MSB];
  end

  assign trigLvl  = syncChain[SYNC_MSB];
  assign trigRise = trigLvl & ~lvlPrev;
  assign cntOne   = (cnt == CNT_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strb.ldStart) cnt <= startDly;
    else if (strb.ldLen)   cnt <= gateLen;
    else if (strb.ldStop)  cnt <= stopDly;
    else if (strb.dec)     cnt <= cnt - CNT_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             gateOut <= 1'b0;
    else if (strb.setGate) gateOut <= 1'b1;
    else if (strb.clrGate) gateOut <= 1'b0;
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.dec |-> cnt != '0);  // R3

  AST_GATE_SET_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setGate && !strb.clrGate) |=> gateOut);  // R1

endmodule

// File: rtl/trig_gate_ctrl.sv
module trig_gate_ctrl
  import trig_gate_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fixedMode,
  input  logic [CNT_W-1:0] gateLen,
  input  logic [CNT_W-1:0] startDly,
  input  logic [CNT_W-1:0] stopDly,
  input  logic             trigRise,
  input  logic             trigLvl,
  input  logic             cntOne,
  output gateStrb_t        strb
);

  gateState_t state, stateNxt;
  logic lenZero, startZero, stopZero;

  assign lenZero   = (gateLen == '0);
  assign startZero = (startDly == '0);
  assign stopZero  = (stopDly == '0);

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (trigRise) begin
          if (!startZero) begin
            strb.ldStart = 1'b1;
            stateNxt     = ST_DELAY;
          end else if (fixedMode && lenZero) begin
            stateNxt = ST_IDLE;
          end else begin
            strb.setGate = 1'b1;
            strb.ldLen   = fixedMode;
            stateNxt     = ST_OPEN;
          end
        end
      end
      ST_DELAY: begin
        if (cntOne) begin
          if (fixedMode && lenZero) begin
            stateNxt = ST_IDLE;
          end else begin
            strb.setGate = 1'b1;
            strb.ldLen   = fixedMode;
            stateNxt     = ST_OPEN;
          end
        end else begin
          strb.dec = 1'b1;
        end
      end
      ST_OPEN: begin
        if (fixedMode) begin
          if (cntOne) begin
            strb.clrGate = 1'b1;
            stateNxt     = ST_IDLE;
          end else begin
            strb.dec = 1'b1;
          end
        end else if (!trigLvl) begin
          if (stopZero) begin
            strb.clrGate = 1'b1;
            stateNxt     = ST_IDLE;
          end else begin
            strb.ldStop = 1'b1;
            stateNxt    = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (cntOne) begin
          strb.clrGate = 1'b1;
          stateNxt     = ST_IDLE;
        end else begin
          strb.dec = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  AST_FIXED_NO_STOP: assert property (@(posedge clk) disable iff (!rstN)
    fixedMode |-> !strb.ldStop);  // R5

  AST_ZERO_LEN_NO_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (fixedMode && lenZero) |-> !strb.setGate);  // R6

  AST_IDLE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !trigRise) |=> state == ST_IDLE);  // R7

  AST_FOLLOW_HOLDS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (!fixedMode && state == ST_OPEN && trigLvl) |=> state == ST_OPEN);  // R2

endmodule

// File: rtl/trig_gate.sv
module trig_gate #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic             fixedMode,
  input  logic [CNT_W-1:0] gateLen,
  input  logic [CNT_W-1:0] startDly,
  input  logic [CNT_W-1:0] stopDly,
  output logic             gateOut
);

  trig_gate_pkg::gateStrb_t strb;
  logic trigRise, trigLvl, cntOne;

  trig_gate_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fixedMode (fixedMode),
    .gateLen   (gateLen),
    .startDly  (startDly),
    .stopDly   (stopDly),
    .trigRise  (trigRise),
    .trigLvl   (trigLvl),
    .cntOne    (cntOne),
    .strb      (strb)
  );

  trig_gate_dpath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .trigIn   (trigIn),
    .gateLen  (gateLen),
    .startDly (startDly),
    .stopDly  (stopDly),
    .strb     (strb),
    .trigRise (trigRise),
    .trigLvl  (trigLvl),
    .cntOne   (cntOne),
    .gateOut  (gateOut)
  );

  AST_RESET_LOW: assert property (@(posedge clk) !rstN |=> !gateOut);  // R8

endmodule

// File: tb/test_trig_gate.sv
module test_trig_gate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigIn = 1'b0;
  logic        fixedMode = 1'b0;
  logic [31:0] gateLen = '0;
  logic [31:0] startDly = '0;
  logic [31:0] stopDly = '0;
  logic        gateOut;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  int pulses = 0;
  int riseAt = -1;
  int fallAt = -1;
  logic prevG = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trig_gate i_trig_gate (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .fixedMode(fixedMode),
    .gateLen(gateLen), .startDly(startDly), .stopDly(stopDly), .gateOut(gateOut)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (gateOut && !prevG) begin
      pulses = pulses + 1;
      riseAt = cyc;
    end
    if (!gateOut && prevG) fallAt = cyc;
    prevG = gateOut;
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearMon();
    pulses = 0; riseAt = -1; fallAt = -1;
  endtask

  // R8: gate low during and after reset with no strobe edge
  task automatic testReset();
    @(negedge clk);
    check("R8 in reset", int'(gateOut), 0);
    rstN = 1'b1;
    clearMon();
    idle(8);
    check("R8 after release", int'(gateOut), 0);
    check("R8 no pulse", pulses, 0);
  endtask

  // R1 R2 R3 R4: follow mode, strobe high for h cycles
  task automatic testFollow(input int h, input int d, input int s, input string tag);
    int t0, t1;
    fixedMode = 1'b0; gateLen = 32'd3; startDly = d; stopDly = s;
    clearMon();
    @(negedge clk); trigIn = 1'b1; t0 = cyc;
    idle(h);        trigIn = 1'b0; t1 = cyc;
    idle(d + s + 12);
    check({tag, " pulse count"}, pulses, 1);
    check({tag, " rise cycle"}, riseAt, t0 + 3 + d);
    check({tag, " fall cycle"}, fallAt, t1 + 3 + s);
  endtask

  // R3 R5: timed mode, strobe high h cycles, stop delay must not matter
  task automatic testFixed(input int l, input int d, input int h, input string tag);
    int t0;
    fixedMode = 1'b1; gateLen = l; startDly = d; stopDly = 32'd7;
    clearMon();
    @(negedge clk); trigIn = 1'b1; t0 = cyc;
    idle(h);        trigIn = 1'b0;
    idle(d + l + 12);
    check({tag, " pulse count"}, pulses, 1);
    check({tag, " rise cycle"}, riseAt, t0 + 3 + d);
    check({tag, " length"}, fallAt - riseAt, l);
  endtask

  // R6: zero length yields no gate
  task automatic testZeroLen(input int d);
    fixedMode = 1'b1; gateLen = 32'd0; startDly = d; stopDly = 32'd0;
    clearMon();
    @(negedge clk); trigIn = 1'b1;
    idle(6); trigIn = 1'b0;
    idle(d + 12);
    check("R6 zero length no pulse", pulses, 0);
    check("R6 gate low", int'(gateOut), 0);
  endtask

  // R7: extra strobe edges during start delay and during open gate
  task automatic testRetrigger();
    int t0;
    fixedMode = 1'b1; gateLen = 32'd20; startDly = 32'd10; stopDly = 32'd0;
    clearMon();
    @(negedge clk); trigIn = 1'b1; t0 = cyc;
    idle(2); trigIn = 1'b0;
    idle(3); trigIn = 1'b1;
    idle(2); trigIn = 1'b0;
    idle(10); trigIn = 1'b1;
    idle(3); trigIn = 1'b0;
    idle(3); trigIn = 1'b1;
    idle(3); trigIn = 1'b0;
    idle(30);
    check("R7 single pulse", pulses, 1);
    check("R7 rise from first edge", riseAt, t0 + 3 + 10);
    check("R7 length unchanged", fallAt - riseAt, 20);
  endtask

  initial begin
    testReset();
    testFollow(12, 0, 0, "R1 R2 follow plain");
    testFollow(5, 0, 0, "R2 follow short");
    testFollow(20, 6, 0, "R3 follow start delay");
    testFollow(9, 0, 4, "R4 follow stop delay");
    testFollow(25, 3, 11, "R4 follow both delays");
    testFixed(6, 0, 2, "R5 fixed short strobe");
    testFixed(8, 5, 3, "R3 R5 fixed start delay");
    testFixed(4, 0, 30, "R5 R7 fixed strobe held");
    testFixed(1, 0, 3, "R5 fixed length one");
    testZeroLen(0);
    testZeroLen(4);
    testRetrigger();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule